// File: doc/BRIEF.md
# Superscalar Register Rename Unit

This block renames a group of up to `SLOTS` instructions in a single cycle. Each slot names two source registers and one destination register as architectural indices. The block returns physical tags for the sources and a fresh physical tag for the destination. A mapping table holds one entry per architectural register. Each entry records the tag of the newest version of that register. Tags `0 .. ARCH_REGS-1` stand for the committed values in the architectural register file, and the remaining tags form the pool that can be handed out.

Dependencies inside a group are resolved as the group is renamed. A source that names a register written by an earlier slot of the same group takes that slot's new tag instead of the table entry. When several slots write the same register, only the youngest of them updates the table. Each branch in the group saves a snapshot of the table, taken as the table stands just after that branch's own slot, into a ring of checkpoints. A misprediction restores the table from the branch's snapshot and discards every younger snapshot. A separate drain-recovery input points every entry back at the architectural file and refills the pool; it is meant for use once the pipeline is empty.

Tags retired at commit come back through a release port. Tags of squashed instructions also return through that port. When the pool cannot cover the group's destinations, or the ring cannot hold all of its branches, the whole group stalls and changes no state.

Top module: `rename_unit`

## Requirements
- R1: After reset, every table entry `r` holds tag `r`. The pool holds every tag from `ARCH_REGS` to `PHYS_REGS-1`, and no checkpoint is live.
- R2: A non-immediate source of a taken slot gets the table entry of its register when no earlier slot of the same group writes that register.
- R3: A non-immediate source in slot k that matches the destination of a writing earlier slot gets the new tag of the youngest such slot.
- R4: A source whose immediate flag is set is not renamed. Its tag output equals the source field zero-extended, and it is never replaced by a same-group tag.
- R5: A slot writes a register when it is valid, its destination enable is 1 and its destination is not register 0. Writing slots of a taken group receive the lowest-numbered free tags, in ascending slot order. Other slots output tag 0 and consume no tag.
- R6: After a taken group, the table entry of each written register holds the tag of the last slot in the group that writes it.
- R7: A group with at least one valid slot stalls (`groupStall`=1, `groupTake`=0, no state change) when its writing slots outnumber the free tags.
- R8: A group stalls when its valid branch slots outnumber the free checkpoint slots, out of `CKPTS`.
- R9: The branches of a taken group get consecutive checkpoint indices (modulo `CKPTS`), in slot order, starting just after the youngest live checkpoint. Each snapshot equals the table as it stands after that branch's slot.
- R10: `recValid` with a live index `recCkpt` restores the table from that checkpoint, one cycle later. It keeps that checkpoint and all older ones, and frees all younger ones.
- R11: `ckRetire` frees the oldest live checkpoint. When no checkpoint is live, it has no effect.
- R12: `drainReset` returns the table, the pool and the checkpoint ring to the R1 state on the next cycle. It takes priority over recovery, release and retire.
- R13: A tag on an active release lane becomes allocatable from the next cycle on.
- R14: No group is taken in a cycle with `recValid` or `drainReset` set; such a group sees `groupStall`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slotValid | input | SLOTS | Slot holds an instruction |
| srcAReg | input | SLOTS*AW | First source register or immediate field |
| srcAImm | input | SLOTS | First source is an immediate |
| srcBReg | input | SLOTS*AW | Second source register or immediate field |
| srcBImm | input | SLOTS | Second source is an immediate |
| dstEn | input | SLOTS | Slot has a destination |
| dstReg | input | SLOTS*AW | Destination register |
| isBranch | input | SLOTS | Slot is a branch needing a checkpoint |
| relValid | input | SLOTS | Release lane active |
| relTag | input | SLOTS*TW | Tag returned to the pool |
| recValid | input | 1 | Misprediction recovery request |
| recCkpt | input | CW | Checkpoint of the mispredicted branch |
| ckRetire | input | 1 | Free the oldest checkpoint |
| drainReset | input | 1 | Point all entries at the architectural file |
| groupStall | output | 1 | Valid group cannot be taken this cycle |
| groupTake | output | 1 | Group is renamed at the coming edge |
| srcATag | output | SLOTS*TW | Renamed first source |
| srcBTag | output | SLOTS*TW | Renamed second source |
| dstTag | output | SLOTS*TW | New destination tag, 0 if none |
| brCkpt | output | SLOTS*CW | Checkpoint index of a branch slot |

## Verification
The bench builds the block with four slots, eight architectural registers, sixteen physical tags and four checkpoints. With only eight allocatable tags, exhausting the pool takes two full groups. Four checkpoint slots fill after two groups of two branches. Ring wrap-around, stalls on tags, stalls on checkpoints and their mix therefore all occur within short sequences. A sequential reference model renames slot by slot, which gives the same-group bypass and last-writer rules independently of the comparator network. Directed groups are followed by a long mixed sweep over register indices, immediates, branches, releases, recoveries and drains.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic takeGroup;   // commit group renames into the table and snapshots
    logic restoreMap;  // reload the table from a checkpoint
    logic clearMap;    // identity mapping (drain recovery)
  } rnStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int CKPTS     = 4,
  localparam int TW   = $clog2(PHYS_REGS),
  localparam int CW   = $clog2(CKPTS),
  localparam int CNTW = CW + 1,
  localparam int FW   = $clog2(PHYS_REGS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          slotValid,
  input  logic [SLOTS-1:0]          slotWrites,
  input  logic [SLOTS-1:0]          isBranch,
  input  logic [SLOTS-1:0]          relValid,
  input  logic [SLOTS-1:0][TW-1:0]  relTag,
  input  logic                      recValid,
  input  logic [CW-1:0]             recCkpt,
  input  logic                      ckRetire,
  input  logic                      drainReset,
  output logic [SLOTS-1:0][TW-1:0]  newTag,
  output logic [SLOTS-1:0][CW-1:0]  brId,
  output logic [FW-1:0]             freeCount,
  output logic                      groupStall,
  output logic                      groupTake,
  output rnStrobe_t                 strobe
);
  localparam logic [PHYS_REGS-1:0] POOL_INIT =
    {{(PHYS_REGS-ARCH_REGS){1'b1}}, {ARCH_REGS{1'b0}}};

  logic [PHYS_REGS-1:0] freeVec, avail, allocMask, relMask;
  logic [CW-1:0]        ckHead, ckTail, headNext;
  logic [CNTW-1:0]      ckCount, cntNext;
  int                   needCnt, brCnt, freeCnt, ckRoom, brIdx;
  logic                 anyValid, shortTags, shortCk;

  // free-list pick: lowest free tags, slot order
  always_comb begin
    avail     = freeVec;
    allocMask = '0;
    needCnt   = 0;
    for (int k = 0; k < SLOTS; k++) begin
      newTag[k] = '0;
      if (slotWrites[k]) begin
        needCnt = needCnt + 1;
        for (int p = PHYS_REGS - 1; p >= 0; p--)
          if (avail[p]) newTag[k] = TW'(p);
        avail[newTag[k]]     = 1'b0;
        allocMask[newTag[k]] = 1'b1;
      end
    end
  end

  always_comb begin
    freeCnt = 0;
    for (int p = 0; p < PHYS_REGS; p++) freeCnt = freeCnt + int'(freeVec[p]);
  end
  assign freeCount = FW'(freeCnt);

  always_comb begin
    relMask = '0;
    for (int k = 0; k < SLOTS; k++)
      if (relValid[k]) relMask[relTag[k]] = 1'b1;
  end

  // checkpoint index assignment
  assign ckTail = ckHead + ckCount[CW-1:0];
  always_comb begin
    brCnt = 0;
    brIdx = 0;
    for (int k = 0; k < SLOTS; k++) begin
      brId[k] = ckTail + CW'(brIdx);
      if (slotValid[k] && isBranch[k]) begin
        brCnt = brCnt + 1;
        brIdx = brIdx + 1;
      end
    end
  end

  // stall decision
  assign ckRoom     = CKPTS - int'(ckCount);
  assign anyValid   = |slotValid;
  assign shortTags  = needCnt > freeCnt;
  assign shortCk    = brCnt > ckRoom;
  assign groupStall = anyValid & (shortTags | shortCk | recValid | drainReset);
  assign groupTake  = anyValid & ~groupStall;

  assign strobe.takeGroup  = groupTake;
  assign strobe.restoreMap = recValid & ~drainReset;
  assign strobe.clearMap   = drainReset;

  // checkpoint ring bookkeeping
  always_comb begin
    cntNext  = ckCount;
    headNext = ckHead;
    if (recValid)
      cntNext = {1'b0, CW'(recCkpt - ckHead)} + CNTW'(1);
    else if (groupTake)
      cntNext = ckCount + CNTW'(brCnt);
    if (ckRetire && cntNext != '0) begin
      headNext = ckHead + CW'(1);
      cntNext  = cntNext - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeVec <= POOL_INIT;
      ckHead  <= '0;
      ckCount <= '0;
    end else if (drainReset) begin
      freeVec <= POOL_INIT;
      ckHead  <= '0;
      ckCount <= '0;
    end else begin
      freeVec <= (freeVec & ~(groupTake ? allocMask : '0)) | relMask;
      ckHead  <= headNext;
      ckCount <= cntNext;
    end
  end
endmodule

// File: rtl/rename_dpath.sv
module rename_dpath
  import rename_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int CKPTS     = 4,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(CKPTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  rnStrobe_t                 strobe,
  input  logic [SLOTS-1:0]          slotValid,
  input  logic [SLOTS-1:0]          slotWrites,
  input  logic [SLOTS-1:0][AW-1:0]  srcAReg,
  input  logic [SLOTS-1:0]          srcAImm,
  input  logic [SLOTS-1:0][AW-1:0]  srcBReg,
  input  logic [SLOTS-1:0]          srcBImm,
  input  logic [SLOTS-1:0][AW-1:0]  dstReg,
  input  logic [SLOTS-1:0]          isBranch,
  input  logic [SLOTS-1:0][TW-1:0]  newTag,
  input  logic [SLOTS-1:0][CW-1:0]  brId,
  input  logic [CW-1:0]             recCkpt,
  output logic [SLOTS-1:0][TW-1:0]  srcATag,
  output logic [SLOTS-1:0][TW-1:0]  srcBTag
);
  logic [TW-1:0]    mapTab [ARCH_REGS];
  logic [TW-1:0]    ckMem  [CKPTS][ARCH_REGS];
  logic [TW-1:0]    stage  [SLOTS][ARCH_REGS];
  logic [TW-1:0]    cur    [ARCH_REGS];
  logic [SLOTS-1:0] lastWriter;

  // per-slot lookup with same-group override
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [TW-1:0] tagA, tagB;
    always_comb begin
      tagA = mapTab[srcAReg[k]];
      tagB = mapTab[srcBReg[k]];
      for (int j = 0; j < k; j++) begin
        if (slotWrites[j] && dstReg[j] == srcAReg[k]) tagA = newTag[j];
        if (slotWrites[j] && dstReg[j] == srcBReg[k]) tagB = newTag[j];
      end
    end
    assign srcATag[k] = srcAImm[k] ? TW'(srcAReg[k]) : tagA;
    assign srcBTag[k] = srcBImm[k] ? TW'(srcBReg[k]) : tagB;
  end

  // write-port selection: only the youngest writer of a register
  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      lastWriter[k] = slotWrites[k];
      for (int j = k + 1; j < SLOTS; j++)
        if (slotWrites[j] && dstReg[j] == dstReg[k]) lastWriter[k] = 1'b0;
    end
  end

  // table image after each slot, used for branch snapshots
  always_comb begin
    for (int r = 0; r < ARCH_REGS; r++) cur[r] = mapTab[r];
    for (int k = 0; k < SLOTS; k++) begin
      if (slotWrites[k]) cur[dstReg[k]] = newTag[k];
      for (int r = 0; r < ARCH_REGS; r++) stage[k][r] = cur[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH_REGS; r++) mapTab[r] <= TW'(r);
    end else if (strobe.clearMap) begin
      for (int r = 0; r < ARCH_REGS; r++) mapTab[r] <= TW'(r);
    end else if (strobe.restoreMap) begin
      for (int r = 0; r < ARCH_REGS; r++) mapTab[r] <= ckMem[recCkpt][r];
    end else if (strobe.takeGroup) begin
      for (int k = 0; k < SLOTS; k++)
        if (lastWriter[k]) mapTab[dstReg[k]] <= newTag[k];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.takeGroup)
      for (int k = 0; k < SLOTS; k++)
        if (slotValid[k] && isBranch[k])
          for (int r = 0; r < ARCH_REGS; r++) ckMem[brId[k]][r] <= stage[k][r];
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int CKPTS     = 4,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(CKPTS),
  localparam int FW = $clog2(PHYS_REGS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          slotValid,
  input  logic [SLOTS-1:0][AW-1:0]  srcAReg,
  input  logic [SLOTS-1:0]          srcAImm,
  input  logic [SLOTS-1:0][AW-1:0]  srcBReg,
  input  logic [SLOTS-1:0]          srcBImm,
  input  logic [SLOTS-1:0]          dstEn,
  input  logic [SLOTS-1:0][AW-1:0]  dstReg,
  input  logic [SLOTS-1:0]          isBranch,
  input  logic [SLOTS-1:0]          relValid,
  input  logic [SLOTS-1:0][TW-1:0]  relTag,
  input  logic                      recValid,
  input  logic [CW-1:0]             recCkpt,
  input  logic                      ckRetire,
  input  logic                      drainReset,
  output logic                      groupStall,
  output logic                      groupTake,
  output logic [SLOTS-1:0][TW-1:0]  srcATag,
  output logic [SLOTS-1:0][TW-1:0]  srcBTag,
  output logic [SLOTS-1:0][TW-1:0]  dstTag,
  output logic [SLOTS-1:0][CW-1:0]  brCkpt
);
  rnStrobe_t                 strobe;
  logic [SLOTS-1:0]          slotWrites;
  logic [SLOTS-1:0][TW-1:0]  newTag;
  logic [FW-1:0]             freeCount;

  for (genvar k = 0; k < SLOTS; k++) begin : g_wr
    assign slotWrites[k] = slotValid[k] & dstEn[k] & (dstReg[k] != '0);
  end

  assign dstTag = newTag;

  rename_ctrl #(
    .SLOTS(SLOTS), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .CKPTS(CKPTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .slotWrites(slotWrites),
    .isBranch(isBranch), .relValid(relValid), .relTag(relTag),
    .recValid(recValid), .recCkpt(recCkpt), .ckRetire(ckRetire),
    .drainReset(drainReset), .newTag(newTag), .brId(brCkpt),
    .freeCount(freeCount), .groupStall(groupStall), .groupTake(groupTake),
    .strobe(strobe)
  );

  rename_dpath #(
    .SLOTS(SLOTS), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .CKPTS(CKPTS)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .slotValid(slotValid),
    .slotWrites(slotWrites), .srcAReg(srcAReg), .srcAImm(srcAImm),
    .srcBReg(srcBReg), .srcBImm(srcBImm), .dstReg(dstReg), .isBranch(isBranch),
    .newTag(newTag), .brId(brCkpt), .recCkpt(recCkpt),
    .srcATag(srcATag), .srcBTag(srcBTag)
  );
endmodule

// File: rtl/rename_chk.sv
module rename_chk #(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(PHYS_REGS),
  localparam int FW = $clog2(PHYS_REGS + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SLOTS-1:0]          slotValid,
  input logic [SLOTS-1:0]          dstEn,
  input logic [SLOTS-1:0][AW-1:0]  dstReg,
  input logic [SLOTS-1:0]          relValid,
  input logic                      recValid,
  input logic                      drainReset,
  input logic                      groupStall,
  input logic                      groupTake,
  input logic [SLOTS-1:0][TW-1:0]  dstTag,
  input logic [FW-1:0]             freeCount
);
  logic [SLOTS-1:0] wr;
  logic [7:0]       takeCnt, relCnt;
  logic             seen;

  always_comb begin
    takeCnt = '0;
    relCnt  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      wr[k] = slotValid[k] & dstEn[k] & (dstReg[k] != '0);
      if (groupTake && wr[k]) takeCnt = takeCnt + 8'd1;
      if (relValid[k])        relCnt  = relCnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R7
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    groupStall |-> !groupTake);

  // R14
  recover_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid || drainReset) |-> !groupTake);

  // R13
  free_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(drainReset)) |->
      (int'(freeCount) == int'($past(freeCount)) - int'($past(takeCnt)) + int'($past(relCnt))));

  for (genvar k = 0; k < SLOTS; k++) begin : g_k
    // R5
    dst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (groupTake && wr[k]) |-> (int'(dstTag[k]) >= ARCH_REGS));
    // R5
    dst_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (groupTake && !wr[k]) |-> (dstTag[k] == '0));
    for (genvar j = k + 1; j < SLOTS; j++) begin : g_j
      // R5
      dst_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (groupTake && wr[k] && wr[j]) |-> (dstTag[k] != dstTag[j]));
    end
  end
endmodule

bind rename_unit rename_chk #(
  .SLOTS(SLOTS), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .dstEn(dstEn), .dstReg(dstReg),
  .relValid(relValid), .recValid(recValid), .drainReset(drainReset),
  .groupStall(groupStall), .groupTake(groupTake), .dstTag(dstTag),
  .freeCount(freeCount)
);

// File: tb/test_rename_unit.sv
module test_rename_unit;
  localparam int S = 4, A = 8, P = 16, C = 4;
  localparam int AW = 3, TW = 4, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [S-1:0] slotValid, srcAImm, srcBImm, dstEn, isBranch, relValid;
  logic [S-1:0][AW-1:0] srcAReg, srcBReg, dstReg;
  logic [S-1:0][TW-1:0] relTag;
  logic recValid, ckRetire, drainReset;
  logic [CW-1:0] recCkpt;
  logic groupStall, groupTake;
  logic [S-1:0][TW-1:0] srcATag, srcBTag, dstTag;
  logic [S-1:0][CW-1:0] brCkpt;

  always #5 clk = ~clk;

  rename_unit #(.SLOTS(S), .ARCH_REGS(A), .PHYS_REGS(P), .CKPTS(C)) i_rename_unit (
    .clk(clk), .rst_n(rst_n), .slotValid(slotValid), .srcAReg(srcAReg), .srcAImm(srcAImm),
    .srcBReg(srcBReg), .srcBImm(srcBImm), .dstEn(dstEn), .dstReg(dstReg),
    .isBranch(isBranch), .relValid(relValid), .relTag(relTag), .recValid(recValid),
    .recCkpt(recCkpt), .ckRetire(ckRetire), .drainReset(drainReset),
    .groupStall(groupStall), .groupTake(groupTake), .srcATag(srcATag),
    .srcBTag(srcBTag), .dstTag(dstTag), .brCkpt(brCkpt));

  int errors = 0, checks = 0;
  string ctx = "R1";

  // reference model state
  int mMap[A];
  bit mFree[P];
  int mHead = 0, mCnt = 0;
  int mCk[C][A];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, ctx, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int r = 0; r < A; r++) mMap[r] = r;
    for (int p = 0; p < P; p++) mFree[p] = (p >= A);
    mHead = 0;
    mCnt  = 0;
  endtask

  task automatic clearIn();
    slotValid = '0; srcAImm = '0; srcBImm = '0; dstEn = '0; isBranch = '0;
    relValid = '0; srcAReg = '0; srcBReg = '0; dstReg = '0; relTag = '0;
    recValid = 1'b0; recCkpt = '0; ckRetire = 1'b0; drainReset = 1'b0;
  endtask

  task automatic setSlot(int k, int a, bit ai, int b, bit bi, bit de, int d, bit br);
    slotValid[k] = 1'b1;
    srcAReg[k] = AW'(a); srcAImm[k] = ai;
    srcBReg[k] = AW'(b); srcBImm[k] = bi;
    dstEn[k] = de; dstReg[k] = AW'(d); isBranch[k] = br;
  endtask

  // release up to n distinct tags that are currently handed out
  task automatic pickRel(int n);
    int cnt = 0;
    for (int p = A; p < P; p++)
      if (!mFree[p] && cnt < n) begin
        relValid[cnt] = 1'b1;
        relTag[cnt] = TW'(p);
        cnt++;
      end
  endtask

  // one cycle: compare outputs against the model, then advance the model
  task automatic step();
    int tmp[A]; bit ft[P]; bit wrote[A];
    int eA[S], eB[S], eD[S], eI[S];
    int snap[S][A];
    string rA[S], rB[S], why;
    int need = 0, br = 0, fc = 0, bi = 0;
    bit anyV, expStall, expTake, w;
    #2;
    for (int r = 0; r < A; r++) begin tmp[r] = mMap[r]; wrote[r] = 0; end
    for (int p = 0; p < P; p++) begin ft[p] = mFree[p]; fc += int'(mFree[p]); end
    for (int k = 0; k < S; k++) begin
      if (slotValid[k] && dstEn[k] && dstReg[k] != 0) need++;
      if (slotValid[k] && isBranch[k]) br++;
    end
    anyV = |slotValid;
    expStall = anyV && (need > fc || br > C - mCnt || recValid || drainReset);
    expTake = anyV && !expStall;
    why = (recValid || drainReset) ? "R14" : (br > C - mCnt) ? "R8" : "R7";
    for (int k = 0; k < S; k++) begin
      eA[k] = 0; eB[k] = 0; eD[k] = 0; eI[k] = 0; rA[k] = "R2"; rB[k] = "R2";
      if (slotValid[k]) begin
        if (srcAImm[k]) begin eA[k] = int'(srcAReg[k]); rA[k] = "R4"; end
        else begin eA[k] = tmp[srcAReg[k]]; if (wrote[srcAReg[k]]) rA[k] = "R3"; end
        if (srcBImm[k]) begin eB[k] = int'(srcBReg[k]); rB[k] = "R4"; end
        else begin eB[k] = tmp[srcBReg[k]]; if (wrote[srcBReg[k]]) rB[k] = "R3"; end
        w = dstEn[k] && dstReg[k] != 0;
        if (w) begin
          for (int p = P - 1; p >= 0; p--) if (ft[p]) eD[k] = p;
          ft[eD[k]] = 0;
          tmp[dstReg[k]] = eD[k];
          wrote[dstReg[k]] = 1;
        end
        if (isBranch[k]) begin
          eI[k] = (mHead + mCnt + bi) % C;
          bi++;
          for (int r = 0; r < A; r++) snap[k][r] = tmp[r];
        end
      end
    end
    check(groupStall === expStall, why, int'(groupStall), int'(expStall));
    check(groupTake === expTake, why, int'(groupTake), int'(expTake));
    if (expTake)
      for (int k = 0; k < S; k++)
        if (slotValid[k]) begin
          check(int'(srcATag[k]) == eA[k], rA[k], int'(srcATag[k]), eA[k]);
          check(int'(srcBTag[k]) == eB[k], rB[k], int'(srcBTag[k]), eB[k]);
          check(int'(dstTag[k]) == eD[k], "R5", int'(dstTag[k]), eD[k]);
          if (isBranch[k]) check(int'(brCkpt[k]) == eI[k], "R9", int'(brCkpt[k]), eI[k]);
        end
    @(posedge clk);
    if (drainReset) modelReset();
    else begin
      if (recValid) begin
        for (int r = 0; r < A; r++) mMap[r] = mCk[recCkpt][r];
        mCnt = ((int'(recCkpt) - mHead + C) % C) + 1;
      end else if (expTake) begin
        for (int r = 0; r < A; r++) mMap[r] = tmp[r];
        for (int p = 0; p < P; p++) mFree[p] = ft[p];
        for (int k = 0; k < S; k++)
          if (slotValid[k] && isBranch[k])
            for (int r = 0; r < A; r++) mCk[eI[k]][r] = snap[k][r];
        mCnt += br;
      end
      for (int k = 0; k < S; k++) if (relValid[k]) mFree[relTag[k]] = 1;
      if (ckRetire && mCnt > 0) begin mHead = (mHead + 1) % C; mCnt--; end
    end
  endtask

  task automatic nextCycle();
    @(negedge clk);
    clearIn();
  endtask

  task automatic readAll();
    for (int k = 0; k < S; k++) setSlot(k, 2 * k, 0, 2 * k + 1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearIn();
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: identity mapping straight after reset
    ctx = "R1";
    nextCycle(); readAll(); step();

    // R3 and R6: repeated writers of r3, bypass inside the group
    ctx = "R6";
    nextCycle();
    setSlot(0, 3, 0, 1, 0, 1, 3, 0);
    setSlot(1, 3, 0, 2, 0, 1, 3, 0);
    setSlot(2, 3, 0, 5, 0, 1, 5, 0);
    setSlot(3, 5, 0, 3, 0, 1, 3, 0);
    step();
    nextCycle(); readAll(); step();

    // R4: immediates pass through and ignore same-group writers
    ctx = "R4";
    nextCycle();
    setSlot(0, 7, 1, 6, 1, 1, 7, 0);
    setSlot(1, 7, 1, 7, 0, 0, 0, 0);
    setSlot(2, 0, 1, 5, 1, 0, 0, 0);
    setSlot(3, 3, 0, 6, 1, 0, 0, 0);
    step();

    // R5: register zero and missing destinations take no tag
    ctx = "R5";
    nextCycle();
    setSlot(0, 1, 0, 2, 0, 1, 0, 0);
    setSlot(1, 1, 0, 2, 0, 0, 4, 0);
    setSlot(2, 0, 0, 4, 0, 1, 2, 0);
    setSlot(3, 2, 0, 0, 0, 1, 0, 0);
    step();
    nextCycle(); readAll(); step();

    // R7: exhaust the pool
    ctx = "R7";
    for (int i = 0; i < 4; i++) begin
      nextCycle();
      for (int k = 0; k < S; k++) setSlot(k, k, 0, k + 1, 0, 1, k + 1, 0);
      step();
    end

    // R13: releases during a stalled cycle help only from the next cycle
    ctx = "R13";
    nextCycle();
    for (int k = 0; k < S; k++) setSlot(k, k, 0, 7, 0, 1, k + 4, 0);
    pickRel(4);
    step();
    nextCycle();
    for (int k = 0; k < S; k++) setSlot(k, k, 0, 7, 0, 1, k + 4, 0);
    step();

    // R12: drain recovery with a group present (R14 stall)
    ctx = "R12";
    nextCycle(); readAll(); drainReset = 1'b1; step();
    nextCycle(); readAll(); step();

    // R8 and R9: fill the checkpoint ring
    ctx = "R8";
    for (int i = 0; i < 3; i++) begin
      nextCycle();
      setSlot(0, 1, 0, 2, 0, 1, 1, 0);
      setSlot(1, 1, 0, 0, 0, 0, 0, 1);
      setSlot(2, 1, 0, 3, 0, 1, 1, 0);
      setSlot(3, 1, 0, 2, 0, 0, 0, 1);
      step();
    end

    // R10: recover to the first branch, group offered in the same cycle
    ctx = "R10";
    nextCycle(); readAll(); recValid = 1'b1; recCkpt = 2'd0; step();
    nextCycle(); readAll(); step();
    nextCycle(); setSlot(0, 1, 0, 1, 0, 1, 6, 1); step();

    // R11: retire until empty, then a four-branch group fits
    ctx = "R11";
    for (int i = 0; i < 3; i++) begin nextCycle(); ckRetire = 1'b1; step(); end
    nextCycle();
    for (int k = 0; k < S; k++) setSlot(k, k, 0, 6, 0, 0, 0, 1);
    step();
    nextCycle(); ckRetire = 1'b1; setSlot(0, 1, 0, 0, 0, 0, 0, 1); step();

    // mixed sweep
    ctx = "R2";
    for (int n = 0; n < 3000; n++) begin
      nextCycle();
      for (int k = 0; k < S; k++)
        if ($urandom_range(0, 99) < 85)
          setSlot(k, $urandom_range(0, A - 1), $urandom_range(0, 99) < 20,
                  $urandom_range(0, A - 1), $urandom_range(0, 99) < 20,
                  $urandom_range(0, 99) < 70, $urandom_range(0, A - 1),
                  $urandom_range(0, 99) < 15);
      pickRel($urandom_range(0, 3));
      ckRetire = $urandom_range(0, 3) == 0;
      if (mCnt > 0 && $urandom_range(0, 24) == 0) begin
        recValid = 1'b1;
        recCkpt = CW'((mHead + $urandom_range(0, mCnt - 1)) % C);
      end
      if ($urandom_range(0, 299) == 0) drainReset = 1'b1;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule